// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial transmitter and receiver. Three format inputs set the frame. One selects seven or eight data bits. One adds a parity bit after the last data bit. One selects one or two stop bits. Every frame begins with a single low start bit. Data bits follow, least significant first. Stop bits are high, and the line idles high. A frame is therefore 9 to 12 bits long. Parity is even unless the odd-parity input is set.

Both directions run from a shared oversample tick at 16 times the bit rate. A two-bit clock-select input picks the source of that tick:

- `00` and `10`: an internal divider, with the clock pin unused.
- `01`: the internal divider, with the oversample clock also driven onto the clock pin.
- `11`: a clock arriving on the external clock input.

On the transmit side, software places a byte on `tx_data` and pulses `tx_load` while `tx_ready` is high. On the receive side, each frame produces a one-cycle `rx_valid` with the byte and its error flags.

The receiver looks for a high-to-low transition on the idle line. It confirms the start bit at the 8th oversample tick, then samples each later bit every 16 ticks, near the bit's centre.

Top module: `serial_frame_xcvr`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1, `rx_valid` is 0 and `clk_out_en` is 0.
- R2: With `mode_7bit`=0, `par_en`=0, `stop2`=0 a loaded byte goes out as a low start bit, data bit 0 first through bit 7, then one high stop bit, each lasting 16 ticks. `tx_ready` then returns to 1 with `txd` high.
- R3: With `mode_7bit`=1 only `tx_data[6:0]` are sent and bit 7 is ignored; a received 7-bit frame delivers `rx_data[7]`=0.
- R4: With `par_en`=1 a parity bit follows the last data bit; it makes the count of ones over data and parity even when `par_odd`=0 and odd when `par_odd`=1.
- R5: With `stop2`=1 the frame carries two high stop bits, and `tx_ready` stays 0 through the middle of the last one.
- R6: A well-formed received frame raises `rx_valid` for exactly one cycle with the data bits in `rx_data`, least significant bit first, and both error flags 0.
- R7: When `par_en`=1 and the received parity bit disagrees with the selected parity, `rx_perr` is 1 together with `rx_valid`.
- R8: When the first stop bit is sampled low, `rx_ferr` is 1 together with `rx_valid`.
- R9: A low pulse on `rxd` shorter than 8 ticks is discarded at start-bit confirmation and produces no `rx_valid`.
- R10: `clk_sel`=01 sets `clk_out_en` to 1 and drives `clk_out` with one period per oversample tick (DIV system clocks). `clk_sel`=00 sets `clk_out_en` to 0 and holds `clk_out` at 0.
- R11: `clk_sel`=11 takes the oversample tick from rising edges of `ext_clk`, so bit time follows that clock for both directions.
- R12: `tx_load` while `tx_ready` is 0 is ignored; the frame in flight is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_7bit | input | 1 | 1: seven data bits, 0: eight |
| par_en | input | 1 | 1: parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even |
| stop2 | input | 1 | 1: two stop bits, 0: one |
| clk_sel | input | 2 | Oversample clock source select |
| ext_clk | input | 1 | External 16x clock |
| clk_out | output | 1 | Internal 16x clock toward the pin |
| clk_out_en | output | 1 | Drive enable for the clock pin |
| tx_data | input | 8 | Byte to send |
| tx_load | input | 1 | Load strobe, taken when ready |
| tx_ready | output | 1 | Transmitter idle |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle received strobe |
| rx_perr | output | 1 | Parity mismatch, with rx_valid |
| rx_ferr | output | 1 | Stop bit low, with rx_valid |

## Verification
The bench builds the block with DIV=4. An oversample tick then comes every 4 clocks and a bit lasts 64 clocks, so all eight frame formats, error injection and glitch rejection fit in a few thousand cycles each. The external clock is driven at a period of 10 clocks, which makes its bit time clearly different from the internal one. A loopback from `txd` to `rxd` in that mode shows both directions following the external source.

// File: rtl/serial_frame_xcvr.sv
module serial_frame_xcvr #(
  parameter int DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_7bit,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       stop2,
  input  logic [1:0] clk_sel,
  input  logic       ext_clk,
  output logic       clk_out,
  output logic       clk_out_en,
  input  logic [7:0] tx_data,
  input  logic       tx_load,
  output logic       tx_ready,
  output logic       txd,
  input  logic       rxd,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_perr,
  output logic       rx_ferr
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_cnt;
  logic [2:0]    ext_s;
  logic          int_tick, ext_rise, use_ext, tick;

  always_ff @(posedge clk) begin
    if (!rst_n) div_cnt <= '0;
    else if (int_tick) div_cnt <= '0;
    else div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ext_s <= '0;
    else ext_s <= {ext_s[1:0], ext_clk};
  end

  assign int_tick   = (div_cnt == DW'(DIV - 1));
  assign ext_rise   = ext_s[1] & ~ext_s[2];
  assign use_ext    = (clk_sel == 2'b11);
  assign tick       = use_ext ? ext_rise : int_tick;
  assign clk_out_en = (clk_sel == 2'b01);
  assign clk_out    = clk_out_en & (div_cnt < DW'(DIV / 2));

  // transmit: whole frame is prepared at load and shifted out LSB first
  logic [7:0]  tx_m;
  logic        tx_par;
  logic [11:0] tx_frame, tx_sh;
  logic [3:0]  tx_len, tx_left, tx_cnt;
  logic        tx_busy;

  assign tx_m   = {tx_data[7] & ~mode_7bit, tx_data[6:0]};
  assign tx_par = ^tx_m ^ par_odd;
  assign tx_len = 4'd10 - {3'b0, mode_7bit} + {3'b0, par_en} + {3'b0, stop2};

  always_comb begin
    tx_frame    = '1;
    tx_frame[0] = 1'b0;
    if (mode_7bit) begin
      tx_frame[7:1] = tx_m[6:0];
      if (par_en) tx_frame[8] = tx_par;
    end else begin
      tx_frame[8:1] = tx_m;
      if (par_en) tx_frame[9] = tx_par;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_cnt  <= '0;
    end else if (tx_load && !tx_busy) begin
      tx_busy <= 1'b1;
      tx_sh   <= tx_frame;
      tx_left <= tx_len - 4'd1;
      tx_cnt  <= '0;
    end else if (tx_busy && tick) begin
      if (tx_cnt == 4'd15) begin
        tx_cnt <= '0;
        if (tx_left == 4'd0) begin
          tx_busy <= 1'b0;
        end else begin
          tx_sh   <= {1'b1, tx_sh[11:1]};
          tx_left <= tx_left - 4'd1;
        end
      end else begin
        tx_cnt <= tx_cnt + 4'd1;
      end
    end
  end

  assign tx_ready = ~tx_busy;
  assign txd      = tx_busy ? tx_sh[0] : 1'b1;

  // receive
  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS} rx_st_t;
  rx_st_t     rx_st;
  logic [1:0] rx_s;
  logic       rxs, rx_last, rx_pbit;
  logic [3:0] rx_cnt, rx_idx, rx_nd, rx_stop_idx;
  logic [7:0] rx_buf;

  assign rxs         = rx_s[1];
  assign rx_nd       = mode_7bit ? 4'd7 : 4'd8;
  assign rx_stop_idx = rx_nd + {3'b0, par_en};

  always_ff @(posedge clk) begin
    if (!rst_n) rx_s <= 2'b11;
    else rx_s <= {rx_s[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st    <= R_IDLE;
      rx_last  <= 1'b1;
      rx_cnt   <= '0;
      rx_idx   <= '0;
      rx_buf   <= '0;
      rx_pbit  <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
      if (tick) begin
        rx_last <= rxs;
        case (rx_st)
          R_IDLE: if (!rxs && rx_last) begin
            rx_st  <= R_START;
            rx_cnt <= '0;
          end
          R_START: begin
            if (rx_cnt == 4'd6) begin
              rx_cnt <= '0;
              rx_idx <= '0;
              rx_buf <= '0;
              rx_st  <= rxs ? R_IDLE : R_BITS;
            end else begin
              rx_cnt <= rx_cnt + 4'd1;
            end
          end
          R_BITS: begin
            if (rx_cnt == 4'd15) begin
              rx_cnt <= '0;
              rx_idx <= rx_idx + 4'd1;
              if (rx_idx < rx_nd) begin
                rx_buf[rx_idx[2:0]] <= rxs;
              end else if (rx_idx == rx_stop_idx) begin
                rx_data  <= rx_buf;
                rx_valid <= 1'b1;
                rx_perr  <= par_en & (rx_pbit != (^rx_buf ^ par_odd));
                rx_ferr  <= ~rxs;
                rx_st    <= R_IDLE;
              end else begin
                rx_pbit <= rxs;
              end
            end else begin
              rx_cnt <= rx_cnt + 4'd1;
            end
          end
          default: rx_st <= R_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_frame_xcvr_chk.sv
module serial_frame_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_7bit,
  input logic       tx_load,
  input logic       tx_ready,
  input logic       txd,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_perr,
  input logic       rx_ferr
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && tx_ready) |=> (!txd && !tx_ready));

  a_r12_busy_only_by_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(tx_load));

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r7_flags_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_perr || rx_ferr) |-> rx_valid);

  a_r3_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mode_7bit) |-> !rx_data[7]);
endmodule

bind serial_frame_xcvr serial_frame_xcvr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_7bit(mode_7bit), .tx_load(tx_load),
  .tx_ready(tx_ready), .txd(txd), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_perr(rx_perr), .rx_ferr(rx_ferr)
);

// File: tb/serial_frame_xcvr_tb.sv
module serial_frame_xcvr_tb;
  localparam int DIV = 4;
  localparam int T   = 16 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_7bit = 1'b0, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic ext_clk = 1'b0, ext_on = 1'b0;
  logic clk_out, clk_out_en, tx_ready, txd, rxd, rx_valid, rx_perr, rx_ferr;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic tx_load = 1'b0, loop = 1'b0, rx_drv = 1'b1;
  int checks = 0, errors = 0;
  int got_n = 0;
  logic [7:0] got_d;
  logic got_p, got_f;

  always #5 clk = ~clk;
  assign rxd = loop ? txd : rx_drv;

  serial_frame_xcvr #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_7bit(mode_7bit), .par_en(par_en),
    .par_odd(par_odd), .stop2(stop2), .clk_sel(clk_sel), .ext_clk(ext_clk),
    .clk_out(clk_out), .clk_out_en(clk_out_en), .tx_data(tx_data),
    .tx_load(tx_load), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr));

  always begin
    repeat (5) @(negedge clk);
    ext_clk = ext_on ? ~ext_clk : 1'b0;
  end

  always @(posedge clk) if (rx_valid) begin
    got_n <= got_n + 1;
    got_d <= rx_data;
    got_p <= rx_perr;
    got_f <= rx_ferr;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk_frame(logic [7:0] d, logic m7, logic pe, logic odd);
    logic [11:0] f = '1;
    int nd = m7 ? 7 : 8;
    logic p = odd;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      f[1+i] = d[i];
      p ^= d[i];
    end
    if (pe) f[1+nd] = p;
    return f;
  endfunction

  function automatic int mk_len(logic m7, logic pe, logic s2);
    return 10 - int'(m7) + int'(pe) + int'(s2);
  endfunction

  task automatic set_fmt(input logic m7, input logic pe, input logic odd, input logic s2);
    @(negedge clk);
    mode_7bit = m7; par_en = pe; par_odd = odd; stop2 = s2;
  endtask

  task automatic test_reset;
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
    chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
    chk(clk_out_en == 1'b0, "R1 clk_out_en", int'(clk_out_en), 0);
  endtask

  task automatic tx_test(input logic [7:0] d, input logic m7, input logic pe, input logic odd,
                         input logic s2, input bit extra_load, input string req);
    logic [11:0] exp_f = mk_frame(d, m7, pe, odd);
    logic [11:0] seen = '1;
    int n = mk_len(m7, pe, s2);
    int w = 0;
    set_fmt(m7, pe, odd, s2);
    tx_data = d; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    while (txd && w < 4 * DIV) begin @(negedge clk); w++; end
    repeat (8 * DIV) @(negedge clk);
    seen[0] = txd;
    for (int i = 1; i < n; i++) begin
      if (extra_load && i == 2) begin
        tx_data = ~d; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        repeat (T - 1) @(negedge clk);
      end else begin
        repeat (T) @(negedge clk);
      end
      seen[i] = txd;
    end
    chk(seen == exp_f, req, int'(seen), int'(exp_f));
    chk(tx_ready == 1'b0, {req, " busy at last bit"}, int'(tx_ready), 0);
    repeat (T) @(negedge clk);
    chk(tx_ready == 1'b1 && txd == 1'b1, {req, " idle after frame"}, int'({tx_ready, txd}), 3);
  endtask

  task automatic rx_test(input logic [7:0] d, input logic m7, input logic pe, input logic odd,
                         input logic s2, input bit bad_par, input bit bad_stop, input string req);
    logic [11:0] f = mk_frame(d, m7, pe, odd);
    int n = mk_len(m7, pe, s2);
    int nd = m7 ? 7 : 8;
    int n0 = got_n;
    logic [7:0] exp_d = m7 ? {1'b0, d[6:0]} : d;
    if (bad_par && pe) f[1+nd] = ~f[1+nd];
    if (bad_stop) f[1+nd+int'(pe)] = 1'b0;
    set_fmt(m7, pe, odd, s2);
    for (int i = 0; i < n; i++) begin
      rx_drv = f[i];
      repeat (T) @(negedge clk);
    end
    rx_drv = 1'b1;
    repeat (T) @(negedge clk);
    chk(got_n == n0 + 1, {req, " one valid"}, got_n - n0, 1);
    chk(got_d == exp_d, {req, " data"}, int'(got_d), int'(exp_d));
    chk(got_p == (bad_par && pe), {req, " parity flag"}, int'(got_p), int'(bad_par && pe));
    chk(got_f == bad_stop, {req, " framing flag"}, int'(got_f), int'(bad_stop));
  endtask

  task automatic glitch_test;
    int n0 = got_n;
    set_fmt(1'b0, 1'b0, 1'b0, 1'b0);
    rx_drv = 1'b0;
    repeat (4 * DIV) @(negedge clk);
    rx_drv = 1'b1;
    repeat (12 * T) @(negedge clk);
    chk(got_n == n0, "R9 glitch rejected", got_n - n0, 0);
  endtask

  task automatic clkpin_test;
    int edges = 0;
    logic prev;
    @(negedge clk);
    clk_sel = 2'b01;
    @(negedge clk);
    chk(clk_out_en == 1'b1, "R10 pin enabled", int'(clk_out_en), 1);
    prev = clk_out;
    for (int i = 0; i < 10 * T; i++) begin
      @(negedge clk);
      if (clk_out && !prev) edges++;
      prev = clk_out;
    end
    chk(edges >= 159 && edges <= 161, "R10 pin rate", edges, 160);
    clk_sel = 2'b00;
    edges = 0;
    @(negedge clk);
    chk(clk_out_en == 1'b0, "R10 pin disabled", int'(clk_out_en), 0);
    for (int i = 0; i < 4 * T; i++) begin
      @(negedge clk);
      if (clk_out) edges++;
    end
    chk(edges == 0, "R10 pin quiet", edges, 0);
  endtask

  task automatic ext_test;
    int n0 = got_n;
    int w = 0;
    set_fmt(1'b0, 1'b1, 1'b0, 1'b0);
    ext_on = 1'b1; clk_sel = 2'b11; loop = 1'b1;
    repeat (40) @(negedge clk);
    tx_data = 8'h3C; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    repeat (1400) @(negedge clk);
    chk(tx_ready == 1'b0, "R11 bit time follows ext clock", int'(tx_ready), 0);
    while (got_n == n0 && w < 3000) begin @(negedge clk); w++; end
    chk(got_n == n0 + 1 && got_d == 8'h3C && !got_p && !got_f, "R11 loopback byte",
        int'(got_d), 8'h3C);
    repeat (400) @(negedge clk);
    loop = 1'b0; clk_sel = 2'b00; ext_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    tx_test(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 8N1 frame");
    tx_test(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 single one");
    tx_test(8'hAA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3 7-bit tx");
    tx_test(8'h93, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 even parity");
    tx_test(8'h93, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R4 odd parity");
    tx_test(8'h7E, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5 two stops");
    tx_test(8'hF0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R5 parity two stops");
    tx_test(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R12 load while busy");
    rx_test(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 8N1 receive");
    rx_test(8'h6B, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6 8O2 receive");
    rx_test(8'hD5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3 7-bit receive");
    rx_test(8'h4E, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7 parity error");
    rx_test(8'h81, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 framing error");
    glitch_test();
    rx_test(8'h29, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 receive after glitch");
    clkpin_test();
    ext_test();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule